// File: doc/BRIEF.md
# Chained Pipelined Vector Arithmetic Unit

This block pairs a pipelined vector adder with a pipelined vector multiplier around a register file of eight vectors, each holding sixty-four 16-bit integer elements. A command names an operation, a destination and up to two source vectors, or a scalar in place of the first source. The unit then streams one element per clock through the selected pipeline for as many elements as the length input gives at acceptance. Every result element leaves on a write port (register, element index, data) as it is stored. The unit raises a one-cycle done strobe once its last element has been stored.

The file records, for every vector, how many leading elements the unit now writing it has completed. When chaining is on, an instruction that reads a vector still being produced by the other unit consumes element i as soon as element i has been stored. It does not wait for the whole vector. When chaining is off, the reader holds off until the producer has stored its final element. A command is only accepted when its target unit is idle and it would not overwrite a vector that the other unit is writing or reading.

Top module: `vec_chain_unit`

## Requirements
- R1: During reset and in the first cycle after it, issueReady is high, no write strobe and no done strobe is asserted, and every vector element reads as zero.
- R2: For a command accepted in cycle t whose operands are all complete, add result element i appears on the add write port in cycle t+7+i (one read cycle plus a 6-stage pipeline), and multiply result element i appears on the multiply write port in cycle t+8+i (7 stages), one element per clock.
- R3: A command processes min(vecLen, 64) elements in ascending index order starting at 0. A length of 0 writes nothing and gives a done strobe in cycle t+1.
- R4: issueOp bit 1 selects the multiplier and bit 0 selects the scalar form: 00 gives dst=srcA+srcB, 01 gives dst=scalar+srcB, 10 gives dst=srcA*srcB and 11 gives dst=scalar*srcB, element by element, keeping the low 16 bits. In the scalar forms srcA is not read.
- R5: With chainEn high, a command reading a vector that the other unit is producing reads element i in the cycle after the producer's element i appears on its write port. An add accepted at t followed at t+1 by a multiply of its result gives multiply element i in cycle t+15+i.
- R6: With chainEn low, a reader of a vector that the other unit is producing reads no element until the cycle after the producer's last element appears. For the same add/multiply pair at length 64, multiply element 0 appears in cycle t+78.
- R7: issueReady is low while the target unit is active. It is also low when the destination equals the other active unit's destination or one of its vector sources. A command offered while issueReady is low is not accepted and causes no writes.
- R8: Each accepted command gives exactly one single-cycle done strobe on its unit's done output, in the cycle after its last element appears on the write port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| chainEn | input | 1 | Enables element-wise chaining between the units |
| issueValid | input | 1 | Command offered this cycle |
| issueOp | input | 2 | bit1: multiply, bit0: scalar form |
| issueDst | input | 3 | Destination vector |
| issueSrcA | input | 3 | First source vector (vector forms only) |
| issueSrcB | input | 3 | Second source vector |
| issueScalar | input | 16 | Scalar operand for scalar forms |
| vecLen | input | 7 | Element count, clamped to 64 |
| issueReady | output | 1 | Command would be accepted this cycle |
| addWrEn | output | 1 | Add unit stores an element |
| addWrReg | output | 3 | Vector written by the add unit |
| addWrIdx | output | 6 | Element index written by the add unit |
| addWrData | output | 16 | Element value written by the add unit |
| addDone | output | 1 | Add command finished |
| mulWrEn | output | 1 | Multiply unit stores an element |
| mulWrReg | output | 3 | Vector written by the multiply unit |
| mulWrIdx | output | 6 | Element index written by the multiply unit |
| mulWrData | output | 16 | Element value written by the multiply unit |
| mulDone | output | 1 | Multiply command finished |

## Verification
The hard case is a reader that catches up with a producer in mid-vector. The reader must be gated element by element against a write count that is still moving. That only happens when a dependent command is accepted within a cycle or two of its producer. The stimulus therefore issues an add and a multiply of its result on consecutive cycles, once with chaining on and once with it off, and compares the first and last multiply write cycles against the fixed latencies. While the first unit is still streaming, conflicting commands are offered against its destination, its source and its own busy unit, and the probe reads issueReady.

// File: rtl/vau_pkg.sv
package vau_pkg;
  localparam int DATA_W    = 16;
  localparam int NUM_REGS  = 8;
  localparam int MAX_LEN   = 64;
  localparam int NUM_UNITS = 2;
  localparam int ADD_U     = 0;
  localparam int MUL_U     = 1;
  localparam int REG_W     = $clog2(NUM_REGS);
  localparam int IDX_W     = $clog2(MAX_LEN);
  localparam int LEN_W     = $clog2(MAX_LEN + 1);

  // strobes from control to datapath, one set per unit
  typedef struct packed {
    logic              readEn;
    logic [IDX_W-1:0]  idx;
    logic [REG_W-1:0]  srcA;
    logic [REG_W-1:0]  srcB;
    logic              useScalar;
    logic [DATA_W-1:0] scalar;
    logic [REG_W-1:0]  dst;
  } unitStrobe_t;

  typedef struct packed {
    logic              valid;
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] data;
  } wbBus_t;
endpackage

// File: rtl/vau_pipe.sv
module vau_pipe
  import vau_pkg::*;
#(
  parameter int LAT    = 6,
  parameter bit IS_MUL = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [IDX_W-1:0]  inIdx,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output wbBus_t            out
);
  logic [DATA_W-1:0] res;
  logic [LAT-1:0]    vS;
  logic [IDX_W-1:0]  iS [LAT];
  logic [DATA_W-1:0] dS [LAT];

  generate
    if (IS_MUL) begin : gMul
      assign res = a * b;
    end else begin : gAdd
      assign res = a + b;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) vS <= '0;
    else       vS <= {vS[LAT-2:0], inValid};
  end

  always_ff @(posedge clk) begin
    iS[0] <= inIdx;
    dS[0] <= res;
    for (int k = 1; k < LAT; k++) begin
      iS[k] <= iS[k-1];
      dS[k] <= dS[k-1];
    end
  end

  always_comb begin
    out.valid = vS[LAT-1];
    out.idx   = iS[LAT-1];
    out.data  = dS[LAT-1];
  end

  AST_PIPE_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    out.valid |-> $past(inValid, LAT)); // R2
endmodule

// File: rtl/vau_datapath.sv
module vau_datapath
  import vau_pkg::*;
#(
  parameter int ADD_LAT = 6,
  parameter int MUL_LAT = 7
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  unitStrobe_t [NUM_UNITS-1:0]  strobe,
  output wbBus_t      [NUM_UNITS-1:0]  wb
);
  logic [DATA_W-1:0] rf [NUM_REGS][MAX_LEN];
  logic [DATA_W-1:0] opA [NUM_UNITS];
  logic [DATA_W-1:0] opB [NUM_UNITS];

  always_comb begin
    for (int u = 0; u < NUM_UNITS; u++) begin
      opA[u] = strobe[u].useScalar ? strobe[u].scalar
                                   : rf[strobe[u].srcA][strobe[u].idx];
      opB[u] = rf[strobe[u].srcB][strobe[u].idx];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int r = 0; r < NUM_REGS; r++)
        for (int e = 0; e < MAX_LEN; e++)
          rf[r][e] <= '0;
    end else begin
      for (int u = 0; u < NUM_UNITS; u++)
        if (wb[u].valid) rf[strobe[u].dst][wb[u].idx] <= wb[u].data;
    end
  end

  for (genvar g = 0; g < NUM_UNITS; g++) begin : gUnit
    localparam int LAT = (g == ADD_U) ? ADD_LAT : MUL_LAT;
    vau_pipe #(.LAT(LAT), .IS_MUL(g == MUL_U)) uPipe (
      .clk     (clk),
      .rstN    (rstN),
      .inValid (strobe[g].readEn),
      .inIdx   (strobe[g].idx),
      .a       (opA[g]),
      .b       (opB[g]),
      .out     (wb[g])
    );
  end

  AST_ONE_PORT_PER_REG: assert property (@(posedge clk) disable iff (!rstN)
    (wb[ADD_U].valid && wb[MUL_U].valid) |-> (strobe[ADD_U].dst != strobe[MUL_U].dst)); // R7
endmodule

// File: rtl/vau_ctrl.sv
module vau_ctrl
  import vau_pkg::*;
(
  input  logic                                clk,
  input  logic                                rstN,
  input  logic                                chainEn,
  input  logic                                issueValid,
  input  logic [1:0]                          issueOp,
  input  logic [REG_W-1:0]                    issueDst,
  input  logic [REG_W-1:0]                    issueSrcA,
  input  logic [REG_W-1:0]                    issueSrcB,
  input  logic [DATA_W-1:0]                   issueScalar,
  input  logic [LEN_W-1:0]                    vecLen,
  input  logic [NUM_UNITS-1:0]                wbValid,
  input  logic [NUM_UNITS-1:0][IDX_W-1:0]     wbIdx,
  output logic                                issueReady,
  output unitStrobe_t [NUM_UNITS-1:0]         strobe,
  output logic [NUM_UNITS-1:0]                done
);
  logic [NUM_UNITS-1:0] active, useScR, okA, okB;
  logic [REG_W-1:0]     dstR  [NUM_UNITS];
  logic [REG_W-1:0]     srcAR [NUM_UNITS];
  logic [REG_W-1:0]     srcBR [NUM_UNITS];
  logic [DATA_W-1:0]    scalR [NUM_UNITS];
  logic [LEN_W-1:0]     lenR  [NUM_UNITS];
  logic [LEN_W-1:0]     issIdx[NUM_UNITS];
  logic [LEN_W-1:0]     wrPtr [NUM_REGS];
  logic                 tgtUnit, conflict, accept;
  logic [LEN_W-1:0]     lenClamp;

  always_comb begin
    tgtUnit  = issueOp[1];
    lenClamp = (vecLen > LEN_W'(MAX_LEN)) ? LEN_W'(MAX_LEN) : vecLen;
    conflict = 1'b0;
    for (int w = 0; w < NUM_UNITS; w++)
      if (active[w] && (w != int'(tgtUnit)))
        conflict = conflict || (issueDst == dstR[w]) || (issueDst == srcBR[w]) ||
                   (!useScR[w] && (issueDst == srcAR[w]));
    issueReady = !active[tgtUnit] && !conflict;
    accept     = issueValid && issueReady;

    for (int u = 0; u < NUM_UNITS; u++) begin
      okA[u] = 1'b1;
      okB[u] = 1'b1;
      for (int w = 0; w < NUM_UNITS; w++) begin
        if (w != u && active[w]) begin
          if (!useScR[u] && dstR[w] == srcAR[u])
            okA[u] = chainEn && (issIdx[u] < wrPtr[srcAR[u]]);
          if (dstR[w] == srcBR[u])
            okB[u] = chainEn && (issIdx[u] < wrPtr[srcBR[u]]);
        end
      end
      strobe[u].readEn    = active[u] && (issIdx[u] < lenR[u]) && okA[u] && okB[u];
      strobe[u].idx       = issIdx[u][IDX_W-1:0];
      strobe[u].srcA      = srcAR[u];
      strobe[u].srcB      = srcBR[u];
      strobe[u].useScalar = useScR[u];
      strobe[u].scalar    = scalR[u];
      strobe[u].dst       = dstR[u];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active <= '0;
      useScR <= '0;
      done   <= '0;
      for (int u = 0; u < NUM_UNITS; u++) begin
        dstR[u]   <= '0;
        srcAR[u]  <= '0;
        srcBR[u]  <= '0;
        scalR[u]  <= '0;
        lenR[u]   <= '0;
        issIdx[u] <= '0;
      end
      for (int r = 0; r < NUM_REGS; r++) wrPtr[r] <= '0;
    end else begin
      for (int u = 0; u < NUM_UNITS; u++) begin
        done[u] <= 1'b0;
        if (strobe[u].readEn) issIdx[u] <= issIdx[u] + LEN_W'(1);
        if (wbValid[u]) begin
          wrPtr[dstR[u]] <= {1'b0, wbIdx[u]} + LEN_W'(1);
          if (({1'b0, wbIdx[u]} + LEN_W'(1)) == lenR[u]) begin
            active[u] <= 1'b0;
            done[u]   <= 1'b1;
          end
        end
      end
      if (accept) begin
        active[tgtUnit] <= (lenClamp != '0);
        useScR[tgtUnit] <= issueOp[0];
        dstR[tgtUnit]   <= issueDst;
        srcAR[tgtUnit]  <= issueSrcA;
        srcBR[tgtUnit]  <= issueSrcB;
        scalR[tgtUnit]  <= issueScalar;
        lenR[tgtUnit]   <= lenClamp;
        issIdx[tgtUnit] <= '0;
        wrPtr[issueDst] <= '0;
        if (lenClamp == '0) done[tgtUnit] <= 1'b1;
      end
    end
  end

  AST_ONE_WRITER: assert property (@(posedge clk) disable iff (!rstN)
    (active[ADD_U] && active[MUL_U]) |-> (dstR[ADD_U] != dstR[MUL_U])); // R7

  for (genvar g = 0; g < NUM_UNITS; g++) begin : gChk
    AST_LEN_BOUND: assert property (@(posedge clk) disable iff (!rstN)
      active[g] |-> ((issIdx[g] <= lenR[g]) && (lenR[g] <= LEN_W'(MAX_LEN)))); // R3
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
      done[g] |-> !active[g]); // R8
  end
endmodule

// File: rtl/vec_chain_unit.sv
module vec_chain_unit
  import vau_pkg::*;
#(
  parameter int ADD_LAT = 6,
  parameter int MUL_LAT = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              chainEn,
  input  logic              issueValid,
  input  logic [1:0]        issueOp,
  input  logic [REG_W-1:0]  issueDst,
  input  logic [REG_W-1:0]  issueSrcA,
  input  logic [REG_W-1:0]  issueSrcB,
  input  logic [DATA_W-1:0] issueScalar,
  input  logic [LEN_W-1:0]  vecLen,
  output logic              issueReady,
  output logic              addWrEn,
  output logic [REG_W-1:0]  addWrReg,
  output logic [IDX_W-1:0]  addWrIdx,
  output logic [DATA_W-1:0] addWrData,
  output logic              addDone,
  output logic              mulWrEn,
  output logic [REG_W-1:0]  mulWrReg,
  output logic [IDX_W-1:0]  mulWrIdx,
  output logic [DATA_W-1:0] mulWrData,
  output logic              mulDone
);
  unitStrobe_t [NUM_UNITS-1:0]        strobe;
  wbBus_t      [NUM_UNITS-1:0]        wb;
  logic        [NUM_UNITS-1:0]        wbValid, done;
  logic        [NUM_UNITS-1:0][IDX_W-1:0] wbIdx;

  always_comb begin
    for (int u = 0; u < NUM_UNITS; u++) begin
      wbValid[u] = wb[u].valid;
      wbIdx[u]   = wb[u].idx;
    end
  end

  vau_ctrl uCtrl (
    .clk (clk), .rstN (rstN), .chainEn (chainEn), .issueValid (issueValid),
    .issueOp (issueOp), .issueDst (issueDst), .issueSrcA (issueSrcA),
    .issueSrcB (issueSrcB), .issueScalar (issueScalar), .vecLen (vecLen),
    .wbValid (wbValid), .wbIdx (wbIdx), .issueReady (issueReady),
    .strobe (strobe), .done (done)
  );

  vau_datapath #(.ADD_LAT(ADD_LAT), .MUL_LAT(MUL_LAT)) uData (
    .clk (clk), .rstN (rstN), .strobe (strobe), .wb (wb)
  );

  assign addWrEn   = wb[ADD_U].valid;
  assign addWrReg  = strobe[ADD_U].dst;
  assign addWrIdx  = wb[ADD_U].idx;
  assign addWrData = wb[ADD_U].data;
  assign addDone   = done[ADD_U];
  assign mulWrEn   = wb[MUL_U].valid;
  assign mulWrReg  = strobe[MUL_U].dst;
  assign mulWrIdx  = wb[MUL_U].idx;
  assign mulWrData = wb[MUL_U].data;
  assign mulDone   = done[MUL_U];
endmodule

// File: tb/sim_vec_chain_unit.sv
module sim_vec_chain_unit;
  logic clk = 1'b0, rstN = 1'b0, chainEn = 1'b1, issueValid = 1'b0;
  logic [1:0]  issueOp = '0;
  logic [2:0]  issueDst = '0, issueSrcA = '0, issueSrcB = '0;
  logic [15:0] issueScalar = '0;
  logic [6:0]  vecLen = '0;
  logic issueReady, addWrEn, addDone, mulWrEn, mulDone;
  logic [2:0]  addWrReg, mulWrReg;
  logic [5:0]  addWrIdx, mulWrIdx;
  logic [15:0] addWrData, mulWrData;

  vec_chain_unit u0 (.*);

  always #4 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int nChecks = 0, nFail = 0;
  int wrCount[2], firstCyc[2], lastCyc[2], doneCyc[2], doneCnt[2], badVal[2], badReg[2];
  logic [15:0] firstVal[2];
  logic [2:0]  expDst[2];
  logic [15:0] expVal[2][64];
  logic [15:0] model[8][64];

  logic        tEn[2], tDone[2];
  logic [2:0]  tReg[2];
  logic [5:0]  tIdx[2];
  logic [15:0] tData[2];
  always_comb begin
    tEn[0] = addWrEn;  tReg[0] = addWrReg; tIdx[0] = addWrIdx; tData[0] = addWrData; tDone[0] = addDone;
    tEn[1] = mulWrEn;  tReg[1] = mulWrReg; tIdx[1] = mulWrIdx; tData[1] = mulWrData; tDone[1] = mulDone;
  end

  always @(negedge clk) begin
    if (rstN) begin
      for (int u = 0; u < 2; u++) begin
        if (tEn[u]) begin
          if (wrCount[u] == 0) begin firstCyc[u] = cyc; firstVal[u] = tData[u]; end
          lastCyc[u] = cyc;
          if (tData[u] != expVal[u][tIdx[u]] || int'(tIdx[u]) != wrCount[u]) badVal[u]++;
          if (tReg[u] != expDst[u]) badReg[u]++;
          wrCount[u]++;
        end
        if (tDone[u]) begin doneCyc[u] = cyc; doneCnt[u]++; end
      end
    end
  end

  always @(posedge clk) begin
    if (cyc > 20000) begin
      nChecks++; nFail++;
      $display("FAIL watchdog (all requirements): actual cycle=%0d expected below 20000", cyc);
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic clearMon(input int u);
    wrCount[u] = 0; firstCyc[u] = -1; lastCyc[u] = -1; doneCyc[u] = -1;
    doneCnt[u] = 0; badVal[u] = 0; badReg[u] = 0; firstVal[u] = '0;
  endtask

  // expected results computed from R4 with a reference register model
  task automatic prep(input int op, input int dst, input int a, input int b,
                      input logic [15:0] sc, input int len);
    int u = op / 2;
    int n = (len > 64) ? 64 : len;
    logic [15:0] va;
    for (int i = 0; i < n; i++) begin
      va = (op % 2 == 1) ? sc : model[a][i];
      expVal[u][i] = (op / 2 == 1) ? va * model[b][i] : va + model[b][i];
    end
    for (int i = 0; i < n; i++) model[dst][i] = expVal[u][i];
    expDst[u] = dst[2:0];
  endtask

  task automatic doIssue(input int op, input int dst, input int a, input int b,
                         input logic [15:0] sc, input int len, output int acc);
    @(negedge clk);
    issueOp = op[1:0]; issueDst = dst[2:0]; issueSrcA = a[2:0]; issueSrcB = b[2:0];
    issueScalar = sc; vecLen = len[6:0]; issueValid = 1'b1;
    #1;
    while (!issueReady) begin @(negedge clk); #1; end
    acc = cyc;
    @(posedge clk);
    #1 issueValid = 1'b0;
  endtask

  task automatic waitDone(input int u);
    while (doneCnt[u] == 0) @(negedge clk);
  endtask

  // table: op, dst, srcA, srcB, scalar, length, expected element 0
  localparam int NROW = 8;
  localparam int T_OP [NROW] = '{1, 1, 0, 2, 3, 1, 0, 1};
  localparam int T_DST[NROW] = '{1, 2, 3, 4, 5, 1, 6, 7};
  localparam int T_A  [NROW] = '{0, 0, 1, 3, 0, 0, 5, 0};
  localparam int T_B  [NROW] = '{0, 1, 2, 3, 4, 1, 5, 0};
  localparam int T_SC [NROW] = '{5, 3, 0, 0, 1000, 65535, 0, 9};
  localparam int T_LEN[NROW] = '{64, 10, 64, 64, 64, 64, 100, 0};
  localparam int T_E0 [NROW] = '{5, 8, 13, 169, 37928, 4, 10320, 0};

  initial begin
    int acc, ta, tb, u, n, lat;
    for (int r = 0; r < 8; r++) for (int e = 0; e < 64; e++) model[r][e] = '0;
    for (int k = 0; k < 2; k++) begin
      clearMon(k); expDst[k] = '0;
      for (int e = 0; e < 64; e++) expVal[k][e] = '0;
    end

    // reset behaviour
    repeat (3) @(negedge clk);
    check(issueReady == 1'b1, "R1", "issueReady in reset", int'(issueReady), 1);
    check(!addWrEn && !mulWrEn && !addDone && !mulDone, "R1", "strobes in reset",
          int'({addWrEn, mulWrEn, addDone, mulDone}), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(issueReady == 1'b1, "R1", "issueReady after reset", int'(issueReady), 1);
    check(!addWrEn && !mulWrEn && !addDone && !mulDone, "R1", "strobes after reset",
          int'({addWrEn, mulWrEn, addDone, mulDone}), 0);

    // table of independent commands (R2, R3, R4, R8; rows 0-2 read zeros left by reset, R1)
    for (int r = 0; r < NROW; r++) begin
      u = T_OP[r] / 2;
      lat = (u == 1) ? 7 : 6;
      n = (T_LEN[r] > 64) ? 64 : T_LEN[r];
      clearMon(u);
      prep(T_OP[r], T_DST[r], T_A[r], T_B[r], T_SC[r][15:0], T_LEN[r]);
      doIssue(T_OP[r], T_DST[r], T_A[r], T_B[r], T_SC[r][15:0], T_LEN[r], acc);
      waitDone(u);
      repeat (3) @(negedge clk);
      check(wrCount[u] == n, "R3", $sformatf("row %0d element count", r), wrCount[u], n);
      check(badVal[u] == 0 && badReg[u] == 0, "R4", $sformatf("row %0d wrong elements", r),
            badVal[u] + badReg[u], 0);
      if (n > 0) begin
        check(int'(firstVal[u]) == T_E0[r], "R4", $sformatf("row %0d element 0", r),
              int'(firstVal[u]), T_E0[r]);
        check(firstCyc[u] == acc + 1 + lat, "R2", $sformatf("row %0d first write cycle", r),
              firstCyc[u] - acc, 1 + lat);
        check(doneCyc[u] == lastCyc[u] + 1, "R8", $sformatf("row %0d done timing", r),
              doneCyc[u] - lastCyc[u], 1);
      end else begin
        check(doneCyc[u] == acc + 1, "R3", "zero length done cycle", doneCyc[u] - acc, 1);
      end
      check(doneCnt[u] == 1, "R8", $sformatf("row %0d done pulses", r), doneCnt[u], 1);
    end

    // chaining on: dependent multiply follows element by element
    chainEn = 1'b1;
    clearMon(0); clearMon(1);
    prep(1, 1, 0, 0, 16'd7, 64);
    prep(2, 2, 1, 1, 16'd0, 64);
    doIssue(1, 1, 0, 0, 16'd7, 64, ta);
    doIssue(2, 2, 1, 1, 16'd0, 64, tb);
    waitDone(0); waitDone(1);
    repeat (3) @(negedge clk);
    check(tb == ta + 1, "R5", "chained reader accepted next cycle", tb - ta, 1);
    check(firstCyc[1] == ta + 15, "R5", "chained first multiply write", firstCyc[1] - ta, 15);
    check(lastCyc[1] == ta + 78, "R5", "chained last multiply write", lastCyc[1] - ta, 78);
    check(badVal[1] == 0 && wrCount[1] == 64, "R5", "chained values", badVal[1], 0);
    check(badVal[0] == 0 && wrCount[0] == 64, "R4", "producer values", badVal[0], 0);

    // chaining off: dependent multiply waits for the last producer element
    @(negedge clk);
    chainEn = 1'b0;
    clearMon(0); clearMon(1);
    prep(1, 1, 0, 0, 16'd2, 64);
    prep(2, 2, 1, 1, 16'd0, 64);
    doIssue(1, 1, 0, 0, 16'd2, 64, ta);
    doIssue(2, 2, 1, 1, 16'd0, 64, tb);
    waitDone(0); waitDone(1);
    repeat (3) @(negedge clk);
    check(firstCyc[1] == ta + 78, "R6", "unchained first multiply write", firstCyc[1] - ta, 78);
    check(firstCyc[1] > lastCyc[0], "R6", "multiply after producer end", firstCyc[1], lastCyc[0] + 1);
    check(badVal[1] == 0 && wrCount[1] == 64, "R6", "unchained values", badVal[1], 0);
    check(doneCyc[1] == ta + 142, "R8", "unchained done cycle", doneCyc[1] - ta, 142);

    // hazard gating while the adder streams into v3 from v2
    @(negedge clk);
    chainEn = 1'b1;
    clearMon(0); clearMon(1);
    prep(1, 3, 0, 2, 16'd1, 64);
    doIssue(1, 3, 0, 2, 16'd1, 64, ta);
    @(negedge clk);
    issueValid = 1'b0; issueOp = 2'd2; issueDst = 3'd3; issueSrcA = 3'd0; issueSrcB = 3'd0;
    issueScalar = '0; vecLen = 7'd64;
    #1 check(!issueReady, "R7", "ready with same destination", int'(issueReady), 0);
    issueDst = 3'd2;
    #1 check(!issueReady, "R7", "ready with destination being read", int'(issueReady), 0);
    issueOp = 2'd1; issueDst = 3'd5;
    #1 check(!issueReady, "R7", "ready with busy unit", int'(issueReady), 0);
    issueOp = 2'd2; issueDst = 3'd4;
    #1 check(issueReady, "R7", "ready with free destination", int'(issueReady), 1);
    prep(2, 4, 0, 0, 16'd0, 64);
    doIssue(2, 4, 0, 0, 16'd0, 64, tb);
    waitDone(0); waitDone(1);
    repeat (3) @(negedge clk);
    check(badVal[0] == 0 && badReg[0] == 0 && wrCount[0] == 64, "R7", "adder unaffected by probes",
          badVal[0] + badReg[0], 0);
    check(badVal[1] == 0 && badReg[1] == 0 && wrCount[1] == 64, "R7", "only accepted multiply written",
          wrCount[1], 64);

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule